// File: doc/BRIEF.md
# Hot-Swap Bus Connection Controller

This block decides when the two-wire bus of a plug-in card (data and clock) may be joined to a live backplane bus. It watches an enable input and the levels of the four lines: backplane data and clock, card data and clock. It drives a connect strobe that closes both bus switches, an enable for the rising-edge accelerators, and a ready flag. All three are low while the sides are apart. Analog buffering, pull-ups and accelerator circuits sit outside; this is only the sequencer that drives them.

After enable rises, the controller waits through a fixed settling delay. Only after that delay does it start looking at the bus. It then joins the sides once all four lines have stayed high for an unbroken idle window. It also joins them earlier if the backplane shows a stop condition (data rising while clock is high) with every line high. Once joined it stays joined, whatever the bus traffic, until enable falls. Dropping enable separates the sides on the next clock edge, and the whole sequence starts over. Both delays are given in microseconds and turned into cycle counts from the clock frequency parameter.

Top module: `hsw_link_ctrl`

## Requirements
- R1: Out of reset, and for as long as `en_i` is low, `link_o`, `boost_o` and `ready_o` are 0. Activity on any line has no effect on them in that state.
- R2: The clock edge that first samples `en_i` high starts a settling phase of INIT_CYC = CLK_MHZ*INIT_US cycles. No line activity during this phase can cause a connection.
- R3: Once settling ends, the block connects after all four lines, as seen after synchronization, have been high for IDLE_CYC = CLK_MHZ*IDLE_US consecutive cycles. With the lines high throughout, the outputs rise on the clock edge INIT_CYC+IDLE_CYC+1 edges after the edge that first samples `en_i` high.
- R4: Once settling ends, a backplane stop condition connects the block on the edge where it is seen. A stop condition is `bp_sda_i` rising while `bp_scl_i` is high, with all four lines high. If a one-cycle low pulse on `bp_sda_i` is driven after edge k, the outputs rise on edge k+4, provided the block is waiting by then.
- R5: A low on any of `bp_scl_i`, `cd_sda_i` or `cd_scl_i` during the idle wait restarts the idle count from zero. For a one-cycle pulse driven after edge k, the connection then comes on edge k+3+IDLE_CYC.
- R6: `en_i` low on any clock edge makes all three outputs 0 after that edge. The next rise of `en_i` repeats the full settling phase and idle or stop wait.
- R7: `link_o`, `boost_o` and `ready_o` are registered and always carry the same value.
- R8: Once connected, the block stays connected while `en_i` stays high, whatever the line levels.
- R9: Each line passes through a two-flop synchronizer. A change on a line input is first seen by the detection logic two edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable, synchronous to clk |
| bp_sda_i | input | 1 | Backplane data line level |
| bp_scl_i | input | 1 | Backplane clock line level |
| cd_sda_i | input | 1 | Card data line level |
| cd_scl_i | input | 1 | Card clock line level |
| link_o | output | 1 | Closes both bus switches |
| boost_o | output | 1 | Enables rising-edge accelerators |
| ready_o | output | 1 | High when the sides are joined |

## Verification
Two functions can land on the same cycle. The idle window can expire on the very edge where a line pulse reaches the detector. A backplane data pulse can also reset the idle count on one edge and then present a stop condition on the next. The bench slides a single-cycle pulse, one cycle at a time, over every position from early in the settling phase to well after connection. For each position it works out the exact connect cycle: restart plus IDLE_CYC, the stop edge, or the plain idle latency. It compares that prediction against the outputs on every cycle.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [1:0] {
    LK_OFF  = 2'd0,
    LK_INIT = 2'd1,
    LK_WAIT = 2'd2,
    LK_LINK = 2'd3
  } lk_state_t;

  // line vector bit positions
  localparam int LN_BP_SDA = 0;
  localparam int LN_BP_SCL = 1;
  localparam int LN_CD_SDA = 2;
  localparam int LN_CD_SCL = 3;
  localparam int LN_NUM    = 4;
endpackage

// File: rtl/hsw_line_sync.sv
module hsw_line_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] sync_o
);
  // R9: two flops per line
  for (genvar g = 0; g < N; g++) begin : g_line
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= raw_i[g];
        s2_q <= s1_q;
      end
    end
    assign sync_o[g] = s2_q;
  end
endmodule

// File: rtl/hsw_bus_watch.sv
module hsw_bus_watch
  import hsw_pkg::*;
#(
  parameter int IDLE_CYC = 7000,
  localparam int CW = $clog2(IDLE_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed_i,
  input  logic [LN_NUM-1:0] lines_i,
  output logic              idle_hit_o,
  output logic              stop_hit_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          sda_prev_q;
  logic          all_hi;

  assign all_hi = &lines_i;

  // R5: any low line clears the count; R3: saturate at the limit
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!armed_i || !all_hi) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (cnt_q != CW'(IDLE_CYC - 1)) begin
      cnt_d  = cnt_q + CW'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      sda_prev_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      sda_prev_q <= lines_i[LN_BP_SDA];
    end
  end

  assign idle_hit_o = armed_i && all_hi && (cnt_q == CW'(IDLE_CYC - 1));
  // R4: data rose (previous low, now high) while clock high, all lines high
  assign stop_hit_o = armed_i && all_hi && !sda_prev_q;

  // R3
  idle_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(IDLE_CYC - 1));
endmodule

// File: rtl/hsw_link_seq.sv
module hsw_link_seq
  import hsw_pkg::*;
#(
  parameter int INIT_CYC = 6500,
  localparam int IW = $clog2(INIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic idle_hit_i,
  input  logic stop_hit_i,
  output logic armed_o,
  output logic link_o
);
  lk_state_t     st_q, st_d;
  logic [IW-1:0] icnt_q, icnt_d;
  logic          icnt_en;
  logic          link_q, link_d;

  always_comb begin
    st_d    = st_q;
    icnt_d  = icnt_q;
    icnt_en = 1'b0;
    unique case (st_q)
      LK_OFF: if (en_i) begin
        st_d    = LK_INIT;
        icnt_d  = '0;
        icnt_en = 1'b1;
      end
      // R2: settling phase, detector not armed
      LK_INIT: if (icnt_q == IW'(INIT_CYC - 1)) begin
        st_d = LK_WAIT;
      end else begin
        icnt_d  = icnt_q + IW'(1);
        icnt_en = 1'b1;
      end
      LK_WAIT: if (idle_hit_i || stop_hit_i) st_d = LK_LINK;
      LK_LINK: st_d = LK_LINK; // R8
      default: st_d = LK_OFF;
    endcase
    if (!en_i) st_d = LK_OFF; // R6
  end

  assign link_d = (st_d == LK_LINK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LK_OFF;
      icnt_q <= '0;
      link_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      if (icnt_en) icnt_q <= icnt_d;
      link_q <= link_d;
    end
  end

  assign armed_o = (st_q == LK_WAIT);
  assign link_o  = link_q;

  // R6
  en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !link_q);
  // R8
  link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_q && en_i) |=> link_q);
  // R2
  link_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_q) |-> ($past(st_q) == LK_WAIT));
endmodule

// File: rtl/hsw_link_ctrl.sv
module hsw_link_ctrl
  import hsw_pkg::*;
#(
  parameter int CLK_MHZ = 50,
  parameter int INIT_US = 130,
  parameter int IDLE_US = 140
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic bp_sda_i,
  input  logic bp_scl_i,
  input  logic cd_sda_i,
  input  logic cd_scl_i,
  output logic link_o,
  output logic boost_o,
  output logic ready_o
);
  localparam int INIT_CYC = CLK_MHZ * INIT_US;
  localparam int IDLE_CYC = CLK_MHZ * IDLE_US;

  logic [LN_NUM-1:0] raw_lines, sync_lines;
  logic              armed, idle_hit, stop_hit, link;

  always_comb begin
    raw_lines            = '0;
    raw_lines[LN_BP_SDA] = bp_sda_i;
    raw_lines[LN_BP_SCL] = bp_scl_i;
    raw_lines[LN_CD_SDA] = cd_sda_i;
    raw_lines[LN_CD_SCL] = cd_scl_i;
  end

  hsw_line_sync #(.N(LN_NUM)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (raw_lines),
    .sync_o (sync_lines)
  );

  hsw_bus_watch #(.IDLE_CYC(IDLE_CYC)) u_watch (
    .clk        (clk),
    .rst_n      (rst_n),
    .armed_i    (armed),
    .lines_i    (sync_lines),
    .idle_hit_o (idle_hit),
    .stop_hit_o (stop_hit)
  );

  hsw_link_seq #(.INIT_CYC(INIT_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .idle_hit_i (idle_hit),
    .stop_hit_i (stop_hit),
    .armed_o    (armed),
    .link_o     (link)
  );

  // R7: one registered value drives all three
  assign link_o  = link;
  assign boost_o = link;
  assign ready_o = link;
endmodule

// File: tb/hsw_link_ctrl_tb.sv
module hsw_link_ctrl_tb;
  localparam int INIT = 6;
  localparam int IDLE = 10;
  localparam int T    = INIT + 1 + IDLE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [3:0] ln = 4'hF; // 0 bp_sda, 1 bp_scl, 2 cd_sda, 3 cd_scl
  logic link, boost, ready;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  hsw_link_ctrl #(.CLK_MHZ(1), .INIT_US(INIT), .IDLE_US(IDLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en),
    .bp_sda_i(ln[0]), .bp_scl_i(ln[1]), .cd_sda_i(ln[2]), .cd_scl_i(ln[3]),
    .link_o(link), .boost_o(boost), .ready_o(ready)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // mode 0 plain idle, 1 restart pulse, 2 backplane data pulse, 3 enable drop
  task automatic run_case(input int mode, input int k, input int bit_sel, input string req);
    int on;
    int r;
    en = 1'b0;
    ln = 4'hF;
    repeat (4) @(negedge clk);
    en = 1'b1;
    for (int n = 1; n <= 2 * T + 8; n++) begin
      @(negedge clk);
      r = k + 3;
      case (mode)
        1: on = (r >= INIT + 2 && r <= T) ? int'(n >= r + IDLE) : int'(n >= T);
        2: on = (k + 4 >= INIT + 2 && k + 3 <= T) ? int'(n >= k + 4) : int'(n >= T);
        3: on = int'((n >= T && n <= k) || n >= k + 2 + T);
        default: on = int'(n >= T);
      endcase
      chk(req, int'(link), on);
      chk("R7", int'(boost), on);
      chk("R7", int'(ready), on);
      if ((mode == 1 || mode == 2) && n == k) ln[bit_sel] = 1'b0;
      if ((mode == 1 || mode == 2) && n == k + 1) ln[bit_sel] = 1'b1;
      if (mode == 3 && n == k) en = 1'b0;
      if (mode == 3 && n == k + 2) en = 1'b1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run completed)");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", int'(link), 0);
    chk("R1 reset", int'(ready), 0);
    rst_n = 1'b1;
    // R1: enable low, lines idle then stop-like pulses: nothing joins
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      ln[0] = (n % 7 != 3);
      chk("R1", int'(link | boost | ready), 0);
    end
    ln = 4'hF;
    // R3 and R9: plain idle latency
    run_case(0, 0, 0, "R3");
    // R5, R2, R8: restart pulse swept across every position
    for (int k = 1; k <= T + 3; k++) run_case(1, k, 1 + (k % 3), "R5");
    // R4: backplane data pulse gives a stop condition
    for (int k = 1; k <= T + 3; k++) run_case(2, k, 0, "R4");
    // R6: enable drop during settling, waiting and after link
    for (int k = 1; k <= T + 3; k++) run_case(3, k, 0, "R6");
    summary();
    $finish;
  end
endmodule